// File: doc/BRIEF.md
# Interleaved Bitplane Fetch Sequencer

This block reads display bitplane data out of a word-addressed memory on behalf of a video pipeline. Six planes each own a 32-bit word pointer that software loads one 16-bit half at a time. A shared arbiter offers DMA slots to the block one at a time. The block uses an offered slot only if three things hold: the slot's position in a fixed eight-slot schedule names a plane, that plane is inside the configured plane count, and the horizontal and vertical fetch windows are both open. Slots the block does not use are handed back, so a lower-priority requester can take them.

The schedule depends on the resolution mode. Low resolution spreads six plane fetches over eight slots. High resolution fetches four planes twice per eight slots, and the first four slots of a line stay idle. Memory reads are combinational: the address is presented in the slot and the data is captured at the clock edge that ends it. Each plane's pointer then steps forward by one word. Plane 0 is always the last plane fetched in a group. So each plane-0 fetch ends a group, and one cycle later the six held plane words appear together with a single-cycle strobe.

Top module: `bpl_fetch_seq`

## Requirements
- R1: `reg_sel[3:1]` selects plane 0..5 (values 6 and 7 are ignored). `reg_sel[0]=0` writes pointer bits 31:16 and `reg_sel[0]=1` writes bits 15:0, and the other half keeps its value. If a pointer write and a fetch of the same plane fall in one cycle, the fetch uses the old pointer and the written value wins over the increment.
- R2: In low resolution, schedule positions 1, 2, 3, 5, 6 and 7 name planes 3, 5, 1, 2, 4 and 0. Positions 0 and 4 are idle.
- R3: In high resolution, positions 0 to 3 are idle until the position counter first wraps past 7 in the current line. After that, positions with low bits 0, 1, 2 and 3 name planes 3, 1, 2 and 0.
- R4: A named plane is fetched only when its index is less than the plane count. With a count of 0, no slot is ever granted.
- R5: `mem_addr` is the low ADDR_W bits of the fetched plane's pointer. After the fetch, the full 32-bit pointer increments by one, so memory addresses wrap modulo 2^ADDR_W.
- R6: One cycle after a plane-0 fetch, `group_valid` is high for exactly one cycle. `group_data[16*k +: 16]` then holds the latest word fetched for plane k.
- R7: No slot is granted while `dma_en` is low.
- R8: The horizontal window opens in the cycle where `beam_h == hstart` and closes in the cycle where `beam_h == hstop`. The vertical window uses the same rule with `beam_v`, `vstart` and `vstop`. Both windows take effect in the same cycle as the compare.
- R9: On `line_end`, the schedule position and the wrap flag return to 0 only if a fetch happened in that line (counting the current cycle). Otherwise the position carries over.
- R10: A `ctrl_we` write sets the plane count from `ctrl_wdata[2:0]` and high resolution from `ctrl_wdata[3]`. After reset, the count is 0, the mode is low resolution, all pointers are 0 and `group_valid` is low.
- R11: `slot_grant` is high only in a cycle with `slot_offer` high. The schedule position advances once per offered slot while `dma_en` and both windows are open, whether or not the slot is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Pointer half write strobe |
| reg_sel | input | 4 | Plane index in bits 3:1, half select in bit 0 |
| reg_wdata | input | 16 | Pointer half value |
| ctrl_we | input | 1 | Control write strobe |
| ctrl_wdata | input | 4 | Plane count in bits 2:0, high resolution in bit 3 |
| dma_en | input | 1 | Bitplane DMA enable |
| beam_h | input | BEAM_W | Current line cycle |
| beam_v | input | BEAM_W | Current line number |
| hstart | input | BEAM_W | Horizontal window open value |
| hstop | input | BEAM_W | Horizontal window close value |
| vstart | input | BEAM_W | Vertical window open value |
| vstop | input | BEAM_W | Vertical window close value |
| line_end | input | 1 | End-of-line pulse |
| slot_offer | input | 1 | A DMA slot is offered in this cycle |
| slot_grant | output | 1 | The offered slot is consumed by a fetch |
| mem_addr | output | ADDR_W | Word read address, valid while granted |
| mem_rdata | input | 16 | Read data for `mem_addr` in the same cycle |
| group_valid | output | 1 | One-cycle strobe for a complete plane group |
| group_data | output | 96 | Six plane words, plane k in bits 16k+15:16k |

## Verification
The bench sweeps every plane count from 0 to 6 in both resolutions. It also leaves gaps in the slot offers, which would expose a counter that advances per clock instead of per offered slot. A swapped table entry, or a high-resolution schedule that skips its idle lead-in, would show up as a wrong grant or a wrong address.

Directed cases cover the following:
- a pointer crossing the address wrap, which would catch a carry kept out of the high half;
- a line that ends without a fetch, which must keep its position, so an unconditional reset would fetch the wrong plane afterwards;
- window edges on both axes, where an off-by-one compare would grant an extra slot or drop one;
- a pointer write that lands on the same plane's fetch, where the increment must not overwrite the new value.

// File: rtl/bpl_fetch_seq.sv
module bpl_fetch_seq #(
  parameter int ADDR_W = 20,
  parameter int BEAM_W = 9,
  parameter int WORD_W = 16,
  parameter int NPL    = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_we,
  input  logic [3:0]            reg_sel,
  input  logic [WORD_W-1:0]     reg_wdata,
  input  logic                  ctrl_we,
  input  logic [3:0]            ctrl_wdata,
  input  logic                  dma_en,
  input  logic [BEAM_W-1:0]     beam_h,
  input  logic [BEAM_W-1:0]     beam_v,
  input  logic [BEAM_W-1:0]     hstart,
  input  logic [BEAM_W-1:0]     hstop,
  input  logic [BEAM_W-1:0]     vstart,
  input  logic [BEAM_W-1:0]     vstop,
  input  logic                  line_end,
  input  logic                  slot_offer,
  output logic                  slot_grant,
  output logic [ADDR_W-1:0]     mem_addr,
  input  logic [WORD_W-1:0]     mem_rdata,
  output logic                  group_valid,
  output logic [NPL*WORD_W-1:0] group_data
);
  localparam int PTR_W = 2 * WORD_W;
  localparam logic [2:0] IDLE = 3'd7;

  logic [PTR_W-1:0]  ptr_q  [NPL];
  logic [WORD_W-1:0] word_q [NPL];
  logic [2:0] pos_q, cnt_q, pl;
  logic wrap_q, did_q, h_q, v_q, hires_q, valid_q;
  logic h_now, v_now, step, fetch;
  logic [PTR_W-1:0] cur_ptr;

  function automatic logic [2:0] pick(input logic [2:0] p, input logic wr, input logic hr);
    logic [2:0] r;
    r = IDLE;
    if (hr) begin
      if (wr || p[2]) begin
        case (p[1:0])
          2'd0: r = 3'd3;
          2'd1: r = 3'd1;
          2'd2: r = 3'd2;
          default: r = 3'd0;
        endcase
      end
    end else begin
      case (p)
        3'd1: r = 3'd3;
        3'd2: r = 3'd5;
        3'd3: r = 3'd1;
        3'd5: r = 3'd2;
        3'd6: r = 3'd4;
        3'd7: r = 3'd0;
        default: r = IDLE;
      endcase
    end
    return r;
  endfunction

  assign h_now = (h_q || beam_h == hstart) && beam_h != hstop;
  assign v_now = (v_q || beam_v == vstart) && beam_v != vstop;
  assign step  = slot_offer && dma_en && h_now && v_now;
  assign pl    = pick(pos_q, wrap_q, hires_q);
  assign fetch = step && pl != IDLE && pl < cnt_q;

  always_comb begin
    cur_ptr = '0;
    for (int k = 0; k < NPL; k++)
      if (pl == 3'(k)) cur_ptr = ptr_q[k];
  end

  assign slot_grant  = fetch;
  assign mem_addr    = cur_ptr[ADDR_W-1:0];
  assign group_valid = valid_q;

  for (genvar g = 0; g < NPL; g++) begin : g_out
    assign group_data[g*WORD_W +: WORD_W] = word_q[g];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q   <= '0;
      wrap_q  <= 1'b0;
      did_q   <= 1'b0;
      h_q     <= 1'b0;
      v_q     <= 1'b0;
      hires_q <= 1'b0;
      cnt_q   <= '0;
      valid_q <= 1'b0;
      for (int k = 0; k < NPL; k++) begin
        ptr_q[k]  <= '0;
        word_q[k] <= '0;
      end
    end else begin
      h_q     <= h_now;
      v_q     <= v_now;
      valid_q <= fetch && pl == 3'd0;
      if (ctrl_we) begin
        cnt_q   <= ctrl_wdata[2:0];
        hires_q <= ctrl_wdata[3];
      end
      if (line_end && (did_q || fetch)) begin
        pos_q  <= '0;
        wrap_q <= 1'b0;
        did_q  <= 1'b0;
      end else if (step) begin
        pos_q <= pos_q + 3'd1;
        if (pos_q == 3'd7) wrap_q <= 1'b1;
        if (fetch) did_q <= 1'b1;
      end
      for (int k = 0; k < NPL; k++) begin
        if (fetch && pl == 3'(k)) word_q[k] <= mem_rdata;
        if (reg_we && reg_sel[3:1] == 3'(k)) begin
          if (reg_sel[0]) ptr_q[k] <= {ptr_q[k][PTR_W-1:WORD_W], reg_wdata};
          else            ptr_q[k] <= {reg_wdata, ptr_q[k][WORD_W-1:0]};
        end else if (fetch && pl == 3'(k)) begin
          ptr_q[k] <= ptr_q[k] + 1'b1;
        end
      end
    end
  end
endmodule

module bpl_fetch_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       dma_en,
  input logic       slot_offer,
  input logic       slot_grant,
  input logic       group_valid,
  input logic [2:0] cnt_q
);
  // R11
  grant_needs_offer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot_grant |-> slot_offer);
  // R7
  no_grant_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_en |-> !slot_grant);
  // R4
  zero_planes_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == 3'd0) |-> !slot_grant);
  // R6
  strobe_after_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    group_valid |-> $past(slot_grant));
  // R6
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    group_valid |=> !group_valid);
endmodule

bind bpl_fetch_seq bpl_fetch_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .dma_en(dma_en), .slot_offer(slot_offer),
  .slot_grant(slot_grant), .group_valid(group_valid), .cnt_q(cnt_q)
);

// File: tb/bpl_fetch_seq_tb_top.sv
`timescale 1ns/1ps
module bpl_fetch_seq_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, reg_we, ctrl_we, dma_en, line_end, slot_offer;
  logic [3:0] reg_sel, ctrl_wdata;
  logic [15:0] reg_wdata;
  logic [8:0] beam_h, beam_v, hstart, hstop, vstart, vstop;
  logic slot_grant, group_valid;
  logic [19:0] mem_addr;
  logic [15:0] mem_rdata;
  logic [95:0] group_data;

  function automatic logic [15:0] memf(input logic [19:0] a);
    return a[15:0] ^ {a[19:16], 12'h5A5};
  endfunction
  assign mem_rdata = memf(mem_addr);

  bpl_fetch_seq dut_i (.*);

  int checks = 0, fails = 0;
  string cur_tag = "R2";

  logic [31:0] m_ptr [6];
  logic [15:0] m_word [6];
  logic [2:0] m_pos, m_cnt;
  logic m_wrap, m_did, m_h, m_v, m_hires;

  task automatic chk(input logic ok, input string tag, input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] sched(input logic [2:0] p, input logic wr, input logic hr);
    logic [2:0] t [8];
    if (hr) begin
      if (!wr && p < 3'd4) return 3'd7;
      t[0] = 3; t[1] = 1; t[2] = 2; t[3] = 0;
      return t[p % 4];
    end
    t[0] = 7; t[1] = 3; t[2] = 5; t[3] = 1; t[4] = 7; t[5] = 2; t[6] = 4; t[7] = 0;
    return t[p];
  endfunction

  task automatic model_reset();
    for (int k = 0; k < 6; k++) begin m_ptr[k] = 0; m_word[k] = 0; end
    m_pos = 0; m_cnt = 0; m_wrap = 0; m_did = 0; m_h = 0; m_v = 0; m_hires = 0;
  endtask

  task automatic cyc();
    logic hn, vn, stp, ef, ev;
    logic [2:0] pl;
    logic [95:0] eg;
    @(negedge clk); #1;
    hn  = (m_h || beam_h == hstart) && beam_h != hstop;
    vn  = (m_v || beam_v == vstart) && beam_v != vstop;
    stp = slot_offer && dma_en && hn && vn;
    pl  = sched(m_pos, m_wrap, m_hires);
    ef  = stp && pl != 3'd7 && pl < m_cnt;
    chk(slot_grant == ef, slot_offer ? cur_tag : "R11", 96'(slot_grant), 96'(ef));
    if (ef) chk(mem_addr == m_ptr[pl][19:0], "R5 addr", 96'(mem_addr), 96'(m_ptr[pl][19:0]));
    m_h = hn; m_v = vn;
    ev = ef && pl == 0;
    if (ef) m_word[pl] = memf(m_ptr[pl][19:0]);
    for (int k = 0; k < 6; k++) begin
      if (reg_we && reg_sel[3:1] == 3'(k)) begin
        if (reg_sel[0]) m_ptr[k][15:0] = reg_wdata;
        else            m_ptr[k][31:16] = reg_wdata;
      end else if (ef && pl == 3'(k)) m_ptr[k] = m_ptr[k] + 1;
    end
    if (ctrl_we) begin m_cnt = ctrl_wdata[2:0]; m_hires = ctrl_wdata[3]; end
    if (line_end && (m_did || ef)) begin m_pos = 0; m_wrap = 0; m_did = 0; end
    else if (stp) begin
      if (m_pos == 7) m_wrap = 1;
      m_pos = m_pos + 1;
      if (ef) m_did = 1;
    end
    @(posedge clk); #1;
    chk(group_valid == ev, "R6 strobe", 96'(group_valid), 96'(ev));
    if (ev) begin
      for (int k = 0; k < 6; k++) eg[k*16 +: 16] = m_word[k];
      chk(group_data == eg, "R6 data", group_data, eg);
    end
    reg_we = 0; ctrl_we = 0; line_end = 0;
  endtask

  task automatic do_reset();
    rst_n = 0; reg_we = 0; ctrl_we = 0; line_end = 0; slot_offer = 0; dma_en = 1;
    reg_sel = 0; reg_wdata = 0; ctrl_wdata = 0;
    beam_h = 0; beam_v = 0; hstart = 0; hstop = 1; vstart = 0; vstop = 1;
    repeat (2) @(posedge clk);
    @(negedge clk); rst_n = 1;
    model_reset();
  endtask

  task automatic wptr(input int k, input logic [15:0] hi, input logic [15:0] lo);
    slot_offer = 0;
    reg_we = 1; reg_sel = {3'(k), 1'b0}; reg_wdata = hi; cyc();
    reg_we = 1; reg_sel = {3'(k), 1'b1}; reg_wdata = lo; cyc();
  endtask

  task automatic setctrl(input int n, input logic hr);
    slot_offer = 0; ctrl_we = 1; ctrl_wdata = {hr, 3'(n)}; cyc();
  endtask

  task automatic load_ptrs();
    for (int k = 0; k < 6; k++) wptr(k, 16'(k + 1), 16'(k * 16'h0100 + 16'h0010));
  endtask

  initial begin
    #1_500_000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    do_reset();
    // R10: reset state
    chk(group_valid == 0, "R10 valid", 96'(group_valid), 0);
    chk(group_data == 0, "R10 data", group_data, 0);
    cur_tag = "R10";
    slot_offer = 1;
    repeat (4) cyc();

    // Sweep plane counts and resolutions (R2, R3, R4, R11, R9)
    for (int hr = 0; hr < 2; hr++) begin
      for (int n = 0; n < 7; n++) begin
        do_reset();
        load_ptrs();
        setctrl(n, hr[0]);
        cur_tag = (n == 0) ? "R4" : (hr != 0 ? "R3" : "R2");
        for (int i = 0; i < 30; i++) begin
          slot_offer = (i % 5) != 4;
          cyc();
        end
        slot_offer = 0; line_end = 1; cur_tag = "R9"; cyc();
        cur_tag = hr != 0 ? "R3" : "R2";
        for (int i = 0; i < 12; i++) begin slot_offer = 1; cyc(); end
      end
    end

    // R9: a line with no fetch keeps the position
    do_reset();
    load_ptrs();
    cur_tag = "R9";
    slot_offer = 1; repeat (3) cyc();
    slot_offer = 0; line_end = 1; cyc();
    setctrl(6, 0);
    slot_offer = 1; cyc();
    chk(m_pos == 3'd4, "R9 pos", 96'(m_pos), 4);
    repeat (8) cyc();

    // R5: pointer wrap across the address space
    do_reset();
    cur_tag = "R5";
    wptr(0, 16'h000F, 16'hFFFF);
    setctrl(6, 0);
    slot_offer = 1; repeat (17) cyc();
    chk(m_ptr[0] == 32'h0010_0001, "R5 ptr", 96'(m_ptr[0]), 96'h0010_0001);

    // R8: horizontal window edges
    do_reset();
    load_ptrs();
    setctrl(6, 0);
    cur_tag = "R8";
    hstart = 5; hstop = 9; beam_h = 20;
    cyc();
    for (int ln = 0; ln < 2; ln++) begin
      for (int h = 0; h < 16; h++) begin beam_h = 9'(h); slot_offer = 1; cyc(); end
      slot_offer = 0; line_end = 1; cyc();
    end
    // R8: vertical window edges
    hstart = 0; hstop = 400; beam_h = 0; vstart = 2; vstop = 4;
    for (int v = 0; v < 6; v++) begin
      beam_v = 9'(v);
      for (int i = 0; i < 4; i++) begin slot_offer = 1; cyc(); end
    end
    // R7: DMA disabled
    vstart = 0; vstop = 400; beam_v = 0;
    cur_tag = "R7";
    dma_en = 0; slot_offer = 1; repeat (8) cyc();
    dma_en = 1;

    // R1: half writes and write racing a fetch
    do_reset();
    load_ptrs();
    setctrl(6, 0);
    cur_tag = "R1";
    slot_offer = 0; reg_we = 1; reg_sel = {3'd3, 1'b0}; reg_wdata = 16'h000C; cyc();
    chk(m_ptr[3] == 32'h000C_0310, "R1 model", 96'(m_ptr[3]), 96'h000C_0310);
    slot_offer = 1; cyc();
    reg_we = 1; reg_sel = {3'd3, 1'b1}; reg_wdata = 16'h7777; cyc();
    repeat (9) cyc();
    reg_we = 1; reg_sel = 4'b1110; reg_wdata = 16'hFFFF; slot_offer = 0; cyc();
    slot_offer = 1; repeat (8) cyc();

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule